// File: doc/BRIEF.md
# Sync Rate Meter

This block measures the period of the incoming horizontal and vertical sync signals, so that software can work out the line rate and the frame rate of a video source. It takes sync signals that are already clean and of positive polarity, along with the polarity flags found upstream. It keeps two saturating 12-bit period counters. At each vertical measurement event it copies both counts and both polarity flags into a set of held registers, and it sets an interrupt flag. The held values are presented as four bytes, a high byte and a low byte for each axis.

The clock `clk` is the fast counting clock, eight times the reference rate. One horizontal count is one `clk` period, which is one eighth of a reference period. One vertical count is `2**V_DIV_LOG2` clocks. The default of 512 clocks equals 64 reference periods. A vertical event occurs on every rising edge of `vsync`. It also occurs as a timeout when the vertical counter has sat at its maximum for a whole further tick without seeing an edge. In that case the count reads 4095, which means no signal or a rate that is too low.

Top module: `sync_rate_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both held counts become 4095, both held polarity bits become 0 and `irq` becomes 0. The bytes then read hi = 0x0F and lo = 0xFF for both axes.
- R2: A rising edge of an input is the clock edge at which the input is sampled 1 after being sampled 0. If consecutive `hsync` rising edges are P clocks apart, with 1 ≤ P ≤ 4095, the held H count at the next V event is P.
- R3: If the `hsync` period is 4095 clocks or more, the H count saturates and reads 4095. It does not wrap.
- R4: If no `hsync` rising edge falls between two consecutive V events, the H count held at the second event is 4095.
- R5: Two `vsync` rising edges P clocks apart, with P < 4096·2**V_DIV_LOG2, cause a V event at the clock edge of the second rising edge. The held V count is then floor(P / 2**V_DIV_LOG2). The outputs show the new value directly after that edge.
- R6: If a `vsync` rising edge occurs at clock edge t0 and no further edge follows, a timeout V event occurs at edge t0 + 4096·2**V_DIV_LOG2 − 1. At that event the held V count reads 4095.
- R7: The byte packing for each axis is as follows. The lo byte is count bits 7:0. In the hi byte, bit 7 is the polarity flag, bits 6:4 are 0 and bits 3:0 are count bits 11:8.
- R8: Both polarity flags are captured at a V event. The polarity bits in the outputs do not change between events.
- R9: `irq` is set by a V event and stays set until `irq_clr` is sampled 1 at a clock edge. At that edge it clears, unless R10 applies.
- R10: If a V event and `irq_clr` fall on the same clock edge, `irq` ends up set.
- R11: The held counts change only at V events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, 8× reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Clean positive-polarity horizontal sync |
| vsync | input | 1 | Clean positive-polarity vertical sync |
| h_pol_in | input | 1 | Detected horizontal polarity flag |
| v_pol_in | input | 1 | Detected vertical polarity flag |
| irq_clr | input | 1 | Clears the event flag |
| h_cnt_hi | output | 8 | Polarity bit 7, H count bits 11:8 in 3:0 |
| h_cnt_lo | output | 8 | H count bits 7:0 |
| v_cnt_hi | output | 8 | Polarity bit 7, V count bits 11:8 in 3:0 |
| v_cnt_lo | output | 8 | V count bits 7:0 |
| irq | output | 1 | Sticky vertical event flag |

## Verification
The hardest condition to reach from the ports is the vertical timeout. It needs more than four thousand vertical ticks with no `vsync` edge. The bench therefore builds the block with a short vertical tick of 8 clocks. It then counts clock edges from a single `vsync` edge and checks that `irq` is still clear one clock before the computed timeout edge and set one clock after it. The upper boundaries are approached in the same way: an `hsync` period of 4094, 4095 or 5000 clocks, and a `vsync` period only a few clocks short of the timeout. The bench also stops `hsync` for a whole vertical window to bring about the stale-count case.

// File: rtl/srm_pkg.sv
// Package for the sync rate meter.
// Holds the shared byte type and the packing of one axis into its two bytes.
// Assumes counts of at most 12 bits, zero-extended by the caller.
package srm_pkg;

    typedef logic [7:0] byte_t;

    // Packs a polarity flag and a 12-bit count into {hi, lo}
    function automatic logic [15:0] pack_axis(input logic pol, input logic [11:0] cnt);
        return {pol, 3'b000, cnt};
    endfunction

endpackage

// File: rtl/srm_period_meter.sv
// Period meter for one sync input.
// Detects rising edges of sync_in. A saturating counter advances once per tick.
// The tick is every clock when DIV_LOG2 is 0, otherwise once every 2**DIV_LOG2
// clocks through a prescaler that restarts at each edge.
// At an edge it reports done and presents the count reached (cap), then restarts.
// With RESTART_ON_FULL set, a tick that finds the counter full also reports done
// with cap at the maximum, and the count restarts from zero.
// Assumes sync_in is synchronous to clk and free of glitches.
module srm_period_meter #(
    parameter int CNT_W           = 12,
    parameter int DIV_LOG2        = 0,
    parameter bit RESTART_ON_FULL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic             done,
    output logic [CNT_W-1:0] cap
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] CNT_START = (DIV_LOG2 == 0) ? CNT_W'(1) : '0;

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             edge_seen;
    logic             full;
    logic             timeout;

    // Remembers the previous sample of the sync input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    assign edge_seen = sync_in & ~prev_q;

    generate
        if (DIV_LOG2 == 0) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            logic [DIV_LOG2-1:0] pre_q;
            // Prescaler: phase restarts at each edge so the count is edge-aligned
            always_ff @(posedge clk) begin
                if (!rst_n)         pre_q <= '0;
                else if (edge_seen) pre_q <= DIV_LOG2'(1);
                else                pre_q <= pre_q + DIV_LOG2'(1);
            end
            assign tick = &pre_q;
        end
    endgenerate

    assign full    = (cnt_q == CNT_MAX);
    assign timeout = RESTART_ON_FULL && full && tick && !edge_seen;

    // Saturating period counter with restart at an edge or at a timeout
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= CNT_MAX;
        else if (edge_seen)      cnt_q <= CNT_START;
        else if (timeout)        cnt_q <= '0;
        else if (tick && !full)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign done = edge_seen | timeout;
    assign cap  = cnt_q;

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (cnt_q == CNT_START));                                  // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !edge_seen && !timeout) |=> full);                           // R3
    AST_COUNT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_seen && !timeout) |=> (cnt_q >= $past(cnt_q)));                // R5

endmodule

// File: rtl/srm_capture.sv
// Capture stage of the sync rate meter.
// Keeps the last completed H period. At a V event it copies that period, the V
// count and both polarity flags into the held registers, and sets the sticky flag.
// An H period counts only if an H edge was seen since the previous V event;
// otherwise the held H count becomes the maximum.
// Assumes vevent and h_done are single-clock pulses from the period meters.
module srm_capture #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vevent,
    input  logic             h_done,
    input  logic [CNT_W-1:0] h_cap,
    input  logic [CNT_W-1:0] v_cap,
    input  logic             h_pol,
    input  logic             v_pol,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] h_cnt_q,
    output logic [CNT_W-1:0] v_cnt_q,
    output logic             h_pol_q,
    output logic             v_pol_q,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] h_hold_q;
    logic             h_seen_q;

    // Holds the most recently completed H period
    always_ff @(posedge clk) begin
        if (!rst_n)      h_hold_q <= CNT_MAX;
        else if (h_done) h_hold_q <= h_cap;
    end

    // Tracks whether an H edge arrived in the current V window
    always_ff @(posedge clk) begin
        if (!rst_n)      h_seen_q <= 1'b0;
        else if (vevent) h_seen_q <= h_done;
        else if (h_done) h_seen_q <= 1'b1;
    end

    // Loads the held counts and polarity flags at each V event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt_q <= CNT_MAX;
            v_cnt_q <= CNT_MAX;
            h_pol_q <= 1'b0;
            v_pol_q <= 1'b0;
        end else if (vevent) begin
            h_cnt_q <= h_seen_q ? h_hold_q : CNT_MAX;
            v_cnt_q <= v_cap;
            h_pol_q <= h_pol;
            v_pol_q <= v_pol;
        end
    end

    // Sticky event flag; a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (vevent)  irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vevent |=> ($stable(h_cnt_q) && $stable(v_cnt_q)));                   // R11
    AST_POL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vevent |=> ($stable(h_pol_q) && $stable(v_pol_q)));                   // R8
    AST_STALE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (vevent && !h_seen_q) |=> (h_cnt_q == CNT_MAX));                      // R4
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        vevent |=> irq);                                                      // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);                                           // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !vevent) |=> !irq);                                       // R9

endmodule

// File: rtl/sync_rate_meter.sv
// Sync rate meter, top level.
// clk is the counting clock at eight times the reference rate. H ticks every clock.
// V ticks every 2**V_DIV_LOG2 clocks; the default of 512 equals 64 reference periods.
// A V event is a vsync rising edge or a V counter timeout. It latches both counts
// and both polarity flags and sets irq.
// Assumes CNT_W lies between 9 and 12, and that the syncs are clean and synchronous.
module sync_rate_meter #(
    parameter int CNT_W      = 12,
    parameter int V_DIV_LOG2 = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       h_pol_in,
    input  logic       v_pol_in,
    input  logic       irq_clr,
    output logic [7:0] h_cnt_hi,
    output logic [7:0] h_cnt_lo,
    output logic [7:0] v_cnt_hi,
    output logic [7:0] v_cnt_lo,
    output logic       irq
);

    import srm_pkg::*;

    logic             h_done;
    logic             v_done;
    logic [CNT_W-1:0] h_cap;
    logic [CNT_W-1:0] v_cap;
    logic [CNT_W-1:0] h_cnt;
    logic [CNT_W-1:0] v_cnt;
    logic             h_pol_q;
    logic             v_pol_q;
    logic [15:0]      h_word;
    logic [15:0]      v_word;

    srm_period_meter #(
        .CNT_W(CNT_W), .DIV_LOG2(0), .RESTART_ON_FULL(1'b0)
    ) u_h_meter (
        .clk(clk), .rst_n(rst_n), .sync_in(hsync), .done(h_done), .cap(h_cap)
    );

    srm_period_meter #(
        .CNT_W(CNT_W), .DIV_LOG2(V_DIV_LOG2), .RESTART_ON_FULL(1'b1)
    ) u_v_meter (
        .clk(clk), .rst_n(rst_n), .sync_in(vsync), .done(v_done), .cap(v_cap)
    );

    srm_capture #(.CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .vevent(v_done),
        .h_done(h_done), .h_cap(h_cap), .v_cap(v_cap),
        .h_pol(h_pol_in), .v_pol(v_pol_in), .irq_clr(irq_clr),
        .h_cnt_q(h_cnt), .v_cnt_q(v_cnt),
        .h_pol_q(h_pol_q), .v_pol_q(v_pol_q), .irq(irq)
    );

    // Forms the readable byte pairs from the held values
    always_comb begin
        h_word   = pack_axis(h_pol_q, 12'(h_cnt));
        v_word   = pack_axis(v_pol_q, 12'(v_cnt));
        h_cnt_hi = byte_t'(h_word[15:8]);
        h_cnt_lo = byte_t'(h_word[7:0]);
        v_cnt_hi = byte_t'(v_word[15:8]);
        v_cnt_lo = byte_t'(v_word[7:0]);
    end

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt_hi[6:4] == 3'b000) && (v_cnt_hi[6:4] == 3'b000));              // R7

endmodule

// File: tb/sync_rate_meter_test.sv
module sync_rate_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int VDIV_LOG2  = 3;
    localparam int VDIV       = 1 << VDIV_LOG2;
    localparam int CMAX       = 4095;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic       h_pol_in = 1'b0;
    logic       v_pol_in = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] h_cnt_hi, h_cnt_lo, v_cnt_hi, v_cnt_lo;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int h_period = 0;
    int hc = 0;
    bit finished = 1'b0;

    sync_rate_meter #(.CNT_W(12), .V_DIV_LOG2(VDIV_LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .h_pol_in(h_pol_in), .v_pol_in(v_pol_in), .irq_clr(irq_clr),
        .h_cnt_hi(h_cnt_hi), .h_cnt_lo(h_cnt_lo),
        .v_cnt_hi(v_cnt_hi), .v_cnt_lo(v_cnt_lo), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // hsync generator: rising edge every h_period clocks, off when h_period is 0
    always @(negedge clk) begin
        if (h_period == 0) begin
            hsync = 1'b0;
            hc = 0;
        end else begin
            hsync = (hc == 0) || (hc == 1);
            hc = (hc >= h_period - 1) ? 0 : hc + 1;
        end
    end

    function automatic logic [15:0] exp_word(input logic pol, input int cnt);
        return {pol, 3'b000, 12'(cnt)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Two vsync rising edges vp clocks apart; checks the event result one edge later
    task automatic run_window(input string tag, input int hp, input int vp,
                              input bit clr_at_edge, input int exp_h);
        int exp_v;
        h_period = hp;
        if (hp > 0) repeat (2 * hp + 4) @(negedge clk);
        else        repeat (40) @(negedge clk);
        exp_v = vp / VDIV;
        if (exp_v > CMAX) exp_v = CMAX;
        @(negedge clk); vsync = 1'b1;
        for (int i = 1; i < vp; i++) begin
            @(negedge clk);
            if (i == 1) irq_clr = 1'b1;
            if (i == 2) irq_clr = 1'b0;
            if (i == 3) vsync = 1'b0;
        end
        check({tag, " R9 flag cleared before edge"}, {15'd0, irq}, 16'd0);
        @(negedge clk); vsync = 1'b1;
        if (clr_at_edge) irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check({tag, " R5 V count"}, {v_cnt_hi, v_cnt_lo}, exp_word(v_pol_in, exp_v));
        check({tag, " R2 H count"}, {h_cnt_hi, h_cnt_lo}, exp_word(h_pol_in, exp_h));
        check({tag, clr_at_edge ? " R10 event beats clear" : " R9 event sets flag"},
              {15'd0, irq}, 16'd1);
        repeat (3) @(negedge clk); vsync = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 H bytes in reset", {h_cnt_hi, h_cnt_lo}, 16'h0FFF);
        check("R1 V bytes in reset", {v_cnt_hi, v_cnt_lo}, 16'h0FFF);
        check("R1 flag in reset", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_basic();
        run_window("basic", 20, 1000, 1'b0, 20);
        run_window("remainder", 37, 2003, 1'b0, 37);
        run_window("H just below max", 4094, 9000, 1'b0, 4094);
    endtask

    task automatic t_h_saturate();
        run_window("R3 H at max", 4095, 9000, 1'b0, CMAX);
        run_window("R3 H beyond max", 5000, 12000, 1'b0, CMAX);
    endtask

    task automatic t_v_near_max();
        run_window("R5 V near timeout", 20, CMAX * VDIV + 3, 1'b0, 20);
    endtask

    task automatic t_stale();
        h_period = 0;
        run_window("R4 first window", 0, 1000, 1'b0, CMAX);
        run_window("R4 no H edge", 0, 1000, 1'b0, CMAX);
    endtask

    task automatic t_polarity();
        h_pol_in = 1'b1; v_pol_in = 1'b0;
        run_window("R7 pol packing", 30, 1600, 1'b0, 30);
        check("R7 H hi byte layout", {8'd0, h_cnt_hi}, 16'h0080);
        h_pol_in = 1'b0; v_pol_in = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 H pol held", {8'd0, h_cnt_hi}, 16'h0080);
        check("R8 V pol held", {8'd0, v_cnt_hi}, 16'h0000);
        run_window("R8 pol updated", 30, 1600, 1'b0, 30);
        check("R8 V pol at event", {8'd0, v_cnt_hi}, 16'h0080);
        h_pol_in = 1'b0; v_pol_in = 1'b0;
    endtask

    task automatic t_flag();
        run_window("R10 same edge", 25, 800, 1'b1, 25);
        repeat (50) @(negedge clk);
        check("R9 flag sticky", {15'd0, irq}, 16'd1);
        check("R11 held V unchanged", {v_cnt_hi, v_cnt_lo}, exp_word(1'b0, 800 / VDIV));
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R9 flag cleared", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_timeout();
        h_period = 20;
        repeat (50) @(negedge clk);
        @(negedge clk); vsync = 1'b1;
        for (int j = 1; j < CMAX * VDIV + VDIV; j++) begin
            @(negedge clk);
            if (j == 1) irq_clr = 1'b1;
            if (j == 2) irq_clr = 1'b0;
            if (j == 3) vsync = 1'b0;
        end
        check("R6 no event before timeout", {15'd0, irq}, 16'd0);
        @(negedge clk);
        check("R6 timeout event", {15'd0, irq}, 16'd1);
        check("R6 V at max", {v_cnt_hi, v_cnt_lo}, 16'h0FFF);
        check("R6 H still valid", {h_cnt_hi, h_cnt_lo}, exp_word(1'b0, 20));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_h_saturate();
        t_v_near_max();
        t_stale();
        t_polarity();
        t_flag();
        t_timeout();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule